// File: doc/BRIEF.md
# Unsigned Dadda-Tree Multiplier

This block multiplies two unsigned N-bit operands into a 2N-bit product. It works in three steps. An AND array forms every single-bit partial product at once. Stages of full-adders and half-adders then compress the columns until at most two bits remain in each column. A final carry-propagate adder sums the two remaining rows.

Each stage works toward a height target taken from the Dadda series 2, 3, 4, 6, 9, 13, 19, where each term is 1.5 times the previous one, rounded down. The first stage aims at the largest term below N, and the last stage aims at 2. In every stage, a column holding b bits gets floor(b/3) full-adders. A sum stays in its own column and a carry moves one column up. Half-adders are added in only two cases: when a column would otherwise end above its target, or at the lowest column that holds exactly two bits. The second case lets the low product bits bypass the final adder.

A compile-time parameter sets the order in which the bits of a column are wired to the adder inputs: ascending bit index or reversed. Reversing the order changes which bit reaches the fast third full-adder input. It never changes the product.

The operands enter through a valid/ready input stream and the product leaves through a valid/ready output stream. With the output register enabled, the block holds one result. It accepts a new operand pair whenever that slot is empty or is being drained in the same cycle. With the output register disabled, the block is purely combinational: valid and ready pass straight through.

Top module: `dadda_mul`

## Requirements
- R1: When `out_valid` is high, `product` equals the unsigned product of the operand pair that was accepted for it, across the full 2N-bit range.
- R2: The ordering parameter (`ORDER` 0 = ascending bit index within a column, 1 = reversed) never changes the product; both builds give identical results for identical operands.
- R3: The block builds and multiplies correctly for N = 12 and for N = 16.
- R4: A zero operand yields a zero product, and all-ones operands yield (2^N-1)^2.
- R5: Operands each with a single set bit, at positions i and j, yield a product with only bit i+j set.
- R6: With `REG_OUT` = 1, a pair accepted on a clock edge (`in_valid` and `in_ready` both high) shows as `out_valid` high with its product after that same edge.
- R7: With `REG_OUT` = 1, while `out_valid` is high and `out_ready` is low, `out_valid` stays high, `product` holds its value, and `in_ready` is low.
- R8: With `REG_OUT` = 1, `in_ready` is high whenever the output slot is empty or `out_ready` is high. An edge that sees `out_ready` high and `in_valid` low leaves `out_valid` low.
- R9: With `REG_OUT` = 1, an active-low `rst_n` clears `out_valid` at once, and it stays low until a new pair is accepted after release.
- R10: With `REG_OUT` = 0, `product` follows the operands combinationally, `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair is valid |
| in_ready | output | 1 | Block can take an operand pair |
| op_a | input | N | Multiplicand, unsigned |
| op_b | input | N | Multiplier, unsigned |
| out_valid | output | 1 | Product is valid |
| out_ready | input | 1 | Consumer takes the product |
| product | output | 2N | Unsigned product |

## Verification
The bench builds four instances. Two have N = 16 with the output register, one for each ordering, and share one stream under random back-pressure. Two have N = 12 without the register, one for each ordering. The 16-bit pair exercises the six-stage tree and the stall, drain and mid-stream reset behaviour of the result slot. The 12-bit pair covers the five-stage tree and the pass-through handshake. Comparing the two orderings at both sizes shows that the permuted adder wiring leaves every product unchanged, including all-zero, all-one and every single-bit operand combination.

// File: rtl/dmul_pkg.sv
package dmul_pkg;
  localparam int MAXCOL = 64;
  localparam int HW     = 8;
  localparam int OW     = 16;

  typedef logic [MAXCOL*HW-1:0] hrow_t;
  typedef logic [MAXCOL*OW-1:0] orow_t;

  // Term j of the height series (term 1 is 2).
  function automatic int dadda_term(int j);
    int d;
    d = 2;
    for (int i = 1; i < j; i++) d = (d * 3) / 2;
    return d;
  endfunction

  // Number of reduction stages for an N-bit operand.
  function automatic int stage_count(int n);
    int d;
    int j;
    d = 2;
    j = 1;
    while ((d * 3) / 2 < n) begin
      d = (d * 3) / 2;
      j++;
    end
    return j;
  endfunction

  // Per-column schedule at stage s. what: 0 = bits held, 1 = full-adders, 2 = half-adders.
  function automatic hrow_t sched_row(int n, int s, int what);
    int    ncol;
    int    nst;
    int    hg[MAXCOL];
    int    ff[MAXCOL];
    int    hh[MAXCOL];
    int    nx[MAXCOL];
    hrow_t r;
    ncol = 2 * n;
    nst  = stage_count(n);
    r    = '0;
    for (int k = 0; k < MAXCOL; k++) begin
      hg[k] = 0;
      ff[k] = 0;
      hh[k] = 0;
      nx[k] = 0;
    end
    for (int k = 0; k < ncol - 1; k++)
      hg[k] = ((k < 2*n - 2 - k) ? k : 2*n - 2 - k) + 1;
    for (int t = 0; t <= s; t++) begin
      int d;
      bit seen;
      d    = (t < nst) ? dadda_term(nst - t) : 0;
      seen = 1'b0;
      for (int k = 0; k < MAXCOL; k++) begin
        ff[k] = 0;
        hh[k] = 0;
      end
      if (t < nst) begin
        for (int k = 0; k < ncol - 1; k++) begin
          int cin;
          int outh;
          cin   = (k > 0) ? ff[k-1] + hh[k-1] : 0;
          ff[k] = hg[k] / 3;
          outh  = hg[k] - 2*ff[k] + cin;
          if (outh > d) begin
            hh[k] = outh - d;
            if (hh[k] > (hg[k] - 3*ff[k]) / 2) hh[k] = (hg[k] - 3*ff[k]) / 2;
          end
          if (!seen && hg[k] >= 2) begin
            int nb;
            int nout;
            seen = 1'b1;
            nb   = hg[k+1];
            nout = nb - 2*(nb/3) + ff[k] + 1;
            if (hg[k] == 2 && hh[k] == 0 && nout <= d) hh[k] = 1;
          end
        end
      end
      if (t == s) begin
        for (int k = 0; k < ncol; k++)
          r[k*HW +: HW] = (what == 0) ? 8'(hg[k]) : (what == 1) ? 8'(ff[k]) : 8'(hh[k]);
      end else begin
        for (int k = 0; k < ncol; k++)
          nx[k] = hg[k] - 2*ff[k] - hh[k] + ((k > 0) ? ff[k-1] + hh[k-1] : 0);
        for (int k = 0; k < ncol; k++) hg[k] = nx[k];
      end
    end
    return r;
  endfunction

  // Running bit offset of every column inside a flattened stage vector.
  function automatic orow_t offs_row(hrow_t h);
    orow_t o;
    int    acc;
    o   = '0;
    acc = 0;
    for (int k = 0; k < MAXCOL; k++) begin
      o[k*OW +: OW] = 16'(acc);
      acc += int'(h[k*HW +: HW]);
    end
    return o;
  endfunction

  // Lowest column that still holds two bits after the final stage.
  function automatic int lowest_pair(int n);
    hrow_t h;
    h = sched_row(n, stage_count(n), 0);
    for (int k = 0; k < 2*n; k++)
      if (int'(h[k*HW +: HW]) == 2) return k;
    return 2*n - 1;
  endfunction
endpackage

// File: rtl/dmul_fa.sv
module dmul_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic sum_o,
  output logic cry_o
);
  logic ab_x;
  assign ab_x  = a_i ^ b_i;
  assign sum_o = ab_x ^ c_i;            // c_i crosses one gate to the sum
  assign cry_o = (a_i & b_i) | (ab_x & c_i);
endmodule

// File: rtl/dmul_ha.sv
module dmul_ha (
  input  logic a_i,
  input  logic b_i,
  output logic sum_o,
  output logic cry_o
);
  assign sum_o = a_i ^ b_i;
  assign cry_o = a_i & b_i;
endmodule

// File: rtl/dmul_stage.sv
module dmul_stage
  import dmul_pkg::*;
#(
  parameter int N     = 16,
  parameter int S     = 0,
  parameter int ORDER = 0,
  localparam int    NCOL = 2 * N,
  localparam hrow_t HIN  = sched_row(N, S, 0),
  localparam hrow_t HOUT = sched_row(N, S + 1, 0),
  localparam hrow_t FCNT = sched_row(N, S, 1),
  localparam hrow_t HCNT = sched_row(N, S, 2),
  localparam orow_t OIN  = offs_row(HIN),
  localparam orow_t OOUT = offs_row(HOUT),
  localparam int    TIN  = int'(OIN[NCOL*OW +: OW]),
  localparam int    TOUT = int'(OOUT[NCOL*OW +: OW])
) (
  input  logic [TIN-1:0]  bits_i,
  output logic [TOUT-1:0] bits_o
);
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam int B    = int'(HIN[c*HW +: HW]);
    localparam int F    = int'(FCNT[c*HW +: HW]);
    localparam int H    = int'(HCNT[c*HW +: HW]);
    localparam int IB   = int'(OIN[c*OW +: OW]);
    localparam int OB   = int'(OOUT[c*OW +: OW]);
    localparam int USED = 3*F + 2*H;
    // First slot for this column's carries inside column c+1 of the next stage.
    localparam int CB   = (c < NCOL - 1) ?
                          int'(OOUT[(c+1)*OW +: OW]) + int'(HIN[(c+1)*HW +: HW])
                          - 2*int'(FCNT[(c+1)*HW +: HW]) - int'(HCNT[(c+1)*HW +: HW]) : 0;

    for (genvar j = 0; j < F; j++) begin : g_fa
      localparam int PA = IB + ((ORDER != 0) ? B - 1 - 3*j       : 3*j);
      localparam int PB = IB + ((ORDER != 0) ? B - 1 - (3*j + 1) : 3*j + 1);
      localparam int PC = IB + ((ORDER != 0) ? B - 1 - (3*j + 2) : 3*j + 2);
      dmul_fa u_fa (
        .a_i  (bits_i[PA]),
        .b_i  (bits_i[PB]),
        .c_i  (bits_i[PC]),
        .sum_o(bits_o[OB + j]),
        .cry_o(bits_o[CB + j])
      );
    end

    for (genvar j = 0; j < H; j++) begin : g_ha
      localparam int KA = 3*F + 2*j;
      localparam int PA = IB + ((ORDER != 0) ? B - 1 - KA       : KA);
      localparam int PB = IB + ((ORDER != 0) ? B - 1 - (KA + 1) : KA + 1);
      dmul_ha u_ha (
        .a_i  (bits_i[PA]),
        .b_i  (bits_i[PB]),
        .sum_o(bits_o[OB + F + j]),
        .cry_o(bits_o[CB + F + j])
      );
    end

    for (genvar k = USED; k < B; k++) begin : g_pass
      localparam int PK = IB + ((ORDER != 0) ? B - 1 - k : k);
      assign bits_o[OB + F + H + (k - USED)] = bits_i[PK];
    end
  end
endmodule

// File: rtl/dmul_cpa.sv
module dmul_cpa #(
  parameter int W  = 32,
  parameter int LO = 2
) (
  input  logic [W-1:0]    row_a_i,
  input  logic [W-LO-1:0] row_b_i,
  output logic [W-1:0]    sum_o
);
  // Columns below LO hold a single bit and bypass the adder.
  assign sum_o[LO-1:0] = row_a_i[LO-1:0];
  assign sum_o[W-1:LO] = row_a_i[W-1:LO] + row_b_i;
endmodule

// File: rtl/dmul_reduce.sv
module dmul_reduce
  import dmul_pkg::*;
#(
  parameter int N     = 16,
  parameter int ORDER = 0,
  localparam int NCOL = 2 * N,
  localparam int NST  = stage_count(N),
  localparam int LO   = lowest_pair(N)
) (
  input  logic [N-1:0]       a_i,
  input  logic [N-1:0]       b_i,
  output logic [NCOL-1:0]    row_a_o,
  output logic [NCOL-LO-1:0] row_b_o
);
  for (genvar s = 0; s <= NST; s++) begin : g_lvl
    localparam hrow_t HS = sched_row(N, s, 0);
    localparam orow_t OS = offs_row(HS);
    localparam int    T  = int'(OS[NCOL*OW +: OW]);
    logic [T-1:0] v;

    if (s == 0) begin : g_pp
      for (genvar c = 0; c < NCOL - 1; c++) begin : g_c
        localparam int OC   = int'(OS[c*OW +: OW]);
        localparam int IMIN = (c >= N) ? c - N + 1 : 0;
        for (genvar i = IMIN; i < N && i <= c; i++) begin : g_i
          assign v[OC + i - IMIN] = a_i[i] & b_i[c - i];
        end
      end
    end else begin : g_red
      dmul_stage #(.N(N), .S(s - 1), .ORDER(ORDER)) u_stage (
        .bits_i(g_lvl[s-1].v),
        .bits_o(v)
      );
    end

    if (s == NST) begin : g_rows
      for (genvar c = 0; c < NCOL; c++) begin : g_c
        localparam int HC = int'(HS[c*HW +: HW]);
        localparam int OC = int'(OS[c*OW +: OW]);
        if (HC >= 1) begin : g_a1
          assign row_a_o[c] = v[OC];
        end else begin : g_a0
          assign row_a_o[c] = 1'b0;
        end
        if (c >= LO) begin : g_b
          if (HC == 2) begin : g_b1
            assign row_b_o[c - LO] = v[OC + 1];
          end else begin : g_b0
            assign row_b_o[c - LO] = 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dadda_mul.sv
module dadda_mul
  import dmul_pkg::*;
#(
  parameter int N       = 16,
  parameter int ORDER   = 0,
  parameter bit REG_OUT = 1'b1,
  localparam int PW = 2 * N,
  localparam int LO = lowest_pair(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N-1:0]  op_a,
  input  logic [N-1:0]  op_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] product
);
  logic [PW-1:0]    row_a;
  logic [PW-LO-1:0] row_b;
  logic [PW-1:0]    prod_w;

  dmul_reduce #(.N(N), .ORDER(ORDER)) u_reduce (
    .a_i    (op_a),
    .b_i    (op_b),
    .row_a_o(row_a),
    .row_b_o(row_b)
  );

  dmul_cpa #(.W(PW), .LO(LO)) u_cpa (
    .row_a_i(row_a),
    .row_b_i(row_b),
    .sum_o  (prod_w)
  );

  if (REG_OUT) begin : g_reg
    logic          full_q;
    logic [PW-1:0] prod_q;
    assign in_ready  = !full_q || out_ready;
    assign out_valid = full_q;
    assign product   = prod_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        prod_q <= '0;
      end else if (in_ready) begin
        full_q <= in_valid;
        if (in_valid) prod_q <= prod_w;
      end
    end
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign product   = prod_w;
  end
endmodule

// File: rtl/dadda_mul_chk.sv
module dadda_mul_chk #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int PW = 2 * N
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [N-1:0]  op_a,
  input logic [N-1:0]  op_b,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] product
);
  if (REG_OUT) begin : g_reg
    logic [PW-1:0] ref_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ref_q <= '0;
      else if (in_valid && in_ready) ref_q <= PW'(op_a) * PW'(op_b);
    end

    AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> product == ref_q); // R1
    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid); // R6
    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(product))); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> !out_valid); // R9
  end else begin : g_comb
    AST_COMB_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> product == PW'(op_a) * PW'(op_b)); // R10
  end
endmodule

bind dadda_mul dadda_mul_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .op_a     (op_a),
  .op_b     (op_b),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .product  (product)
);

// File: tb/dadda_mul_tb_top.sv
module dadda_mul_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;

  logic        rdy16, vld16, rdy16r, vld16r;
  logic [31:0] p16, p16r;
  logic        rdy12, vld12, rdy12r, vld12r;
  logic [23:0] p12, p12r;

  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  bit          ended = 1'b0;

  // reference model state for the registered stream
  bit          ev = 1'b0;
  logic [31:0] ep = '0;
  bit          stalled = 1'b0;
  string       ptag = "R1";

  always #2 clk = ~clk;

  dadda_mul #(.N(16), .ORDER(0), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy16),
    .op_a(op_a), .op_b(op_b), .out_valid(vld16), .out_ready(out_ready), .product(p16));

  dadda_mul #(.N(16), .ORDER(1), .REG_OUT(1'b1)) dut_rev16 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy16r),
    .op_a(op_a), .op_b(op_b), .out_valid(vld16r), .out_ready(out_ready), .product(p16r));

  dadda_mul #(.N(12), .ORDER(0), .REG_OUT(1'b0)) dut_asc12 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy12),
    .op_a(op_a[11:0]), .op_b(op_b[11:0]), .out_valid(vld12), .out_ready(out_ready), .product(p12));

  dadda_mul #(.N(12), .ORDER(1), .REG_OUT(1'b0)) dut_rev12 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy12r),
    .op_a(op_a[11:0]), .op_b(op_b[11:0]), .out_valid(vld12r), .out_ready(out_ready), .product(p12r));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // cycle model built from R6..R9
  always @(posedge clk) begin
    cyc++;
    stalled = ev && !out_ready;
    if (!rst_n) ev = 1'b0;
    else if (!ev || out_ready) begin
      ev = in_valid;
      if (in_valid) ep = 32'(op_a) * 32'(op_b);
    end
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cyc);
      finish_run();
    end
  end

  task automatic check_now();
    logic [23:0] e12;
    string vtag;
    e12  = 24'(op_a[11:0]) * 24'(op_b[11:0]);
    vtag = !rst_n ? "R9" : (stalled ? "R7" : "R6");
    chk(vld16 == ev, vtag, 64'(vld16), 64'(ev));
    chk(rdy16 == (!ev || out_ready), stalled ? "R7" : "R8", 64'(rdy16), 64'(!ev || out_ready));
    if (ev) begin
      chk(p16 == ep, ptag, 64'(p16), 64'(ep));
      chk(p16r == p16 && vld16r == vld16, "R2", 64'(p16r), 64'(p16));
    end
    chk(p12 == e12, "R3", 64'(p12), 64'(e12));
    chk(p12r == p12, "R2", 64'(p12r), 64'(p12));
    chk(vld12 == in_valid && rdy12 == out_ready && vld12r == in_valid && rdy12r == out_ready,
        "R10", 64'({vld12, rdy12}), 64'({in_valid, out_ready}));
  endtask

  task automatic tick(input logic [15:0] a, input logic [15:0] b, input bit v, input bit r);
    @(negedge clk);
    check_now();
    op_a = a;
    op_b = b;
    in_valid = v;
    out_ready = r;
  endtask

  initial begin
    // R9: reset state
    for (int i = 0; i < 4; i++) tick(16'h0, 16'h0, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    // R4: zero and all-ones operands
    ptag = "R4";
    tick(16'h0000, 16'hFFFF, 1'b1, 1'b1);
    tick(16'hFFFF, 16'h0000, 1'b1, 1'b1);
    tick(16'hFFFF, 16'hFFFF, 1'b1, 1'b1);
    tick(16'h0FFF, 16'h0FFF, 1'b1, 1'b1);
    tick(16'h0000, 16'h0000, 1'b1, 1'b1);
    // R5: single-bit operands
    ptag = "R5";
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        tick(16'(1 << i), 16'(1 << j), 1'b1, 1'b1);
    // R1, R7, R8: random operands under random back-pressure
    ptag = "R1";
    for (int k = 0; k < 4000; k++)
      tick(16'($urandom), 16'($urandom), ($urandom % 4) != 0, ($urandom % 10) < 7);
    // R7: long stall with a held result
    tick(16'hBEEF, 16'h1234, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) tick(16'($urandom), 16'($urandom), 1'b1, 1'b0);
    // R8: drain with no new input
    tick(16'h0, 16'h0, 1'b0, 1'b1);
    tick(16'h0, 16'h0, 1'b0, 1'b1);
    // R9: reset while the slot is full
    tick(16'hA5A5, 16'h5A5A, 1'b1, 1'b0);
    tick(16'hA5A5, 16'h5A5A, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    tick(16'h0, 16'h0, 1'b0, 1'b0);
    tick(16'h0, 16'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // R3: 12-bit random with both orderings
    for (int k = 0; k < 3000; k++)
      tick(16'($urandom), 16'($urandom), 1'b1, 1'b1);
    tick(16'h0, 16'h0, 1'b0, 1'b1);
    tick(16'h0, 16'h0, 1'b0, 1'b1);
    finish_run();
  end
endmodule